// File: doc/BRIEF.md
# Vertical Strip Scan Sequencer

The sequencer walks an image strip that is a fixed number of lines tall and produces one read address per clock cycle for the strip buffer. Pixels are visited down a column from the top line to the bottom line, and then the walk moves to the top line of the next column to the right. Next to each address it produces a valid strobe, the parity of the current column, and four framing flags that the coding stages downstream use. These flags mark the reference sample, the block that holds it, the start of a segment, and the end of a block. Each column forms exactly one coding block.

A scan begins with a start pulse, and the strip width in columns is captured on that pulse. The blocks of the strip are grouped into reference intervals of R blocks and into segments of S blocks. Both groupings are counted from the first column of the scan. R can be changed at run time with a load strobe and a value. A loaded value waits as pending and takes effect at the next interval boundary, or at the next scan start, whichever comes first. One cycle after the final pixel of the strip, a single-cycle done pulse is raised.

Top module: `vscan_sequencer`

## Requirements
- R1: While a scan runs, valid is high for exactly one cycle per pixel and addr equals column × LINES + row. Rows run from 0 to LINES-1 inside a column and columns run from 0 to width-1. The first pixel (address 0) appears in the cycle after the clock edge that accepts start.
- R2: col_odd equals bit 0 of the current column index while valid is high.
- R3: flag_blk_end is high on row LINES-1 of every column and low on all other rows.
- R4: Blocks are numbered from the scan start and grouped into reference intervals of R blocks each. flag_ref_block is high on every pixel of the first block of an interval. flag_ref is high only on row 0 of that block.
- R5: flag_seg_start is high on row 0 of the first block of every group of SEG_BLOCKS blocks, counted from the scan start.
- R6: After reset, R equals RI_DEFAULT. A ri_load with a nonzero ri_value is held as pending and becomes R at the next interval boundary or scan start. A ri_load with value 0 is ignored.
- R7: done is high for exactly one cycle, which is the cycle after the last pixel of the last column. valid is low in that cycle.
- R8: A start pulse is ignored while a scan is running, and also when width is 0.
- R9: After reset, valid, done, all flags and col_odd are 0, and addr is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a scan when idle and width is nonzero |
| width | input | COL_W | Strip width in columns, captured on start |
| ri_load | input | 1 | Load strobe for the reference-interval length |
| ri_value | input | RI_W | New reference-interval length in blocks |
| addr | output | COL_W+clog2(LINES) | Strip buffer read address |
| valid | output | 1 | One pulse per issued pixel |
| col_odd | output | 1 | Bit 0 of the current column |
| flag_ref | output | 1 | Reference sample (row 0, first block of interval) |
| flag_seg_start | output | 1 | First pixel of a segment |
| flag_ref_block | output | 1 | Pixel belongs to the reference-sample block |
| flag_blk_end | output | 1 | Last pixel of a block |
| done | output | 1 | One-cycle pulse after the last pixel |

## Verification
The bench builds the block with LINES=4, COL_W=5, SEG_BLOCKS=3 and RI_DEFAULT=2. With these values, segment and interval wraps occur within a few columns, and a strip of the largest width (31 columns, 124 pixels) can be swept pixel by pixel. The small values also let one scan cover a pending reload that lands in the middle of an interval, a zero reload that must be ignored, and a one-column strip whose single block is both reference block and segment start.

// File: rtl/vscan_pkg.sv
package vscan_pkg;

  // Framing marks attached to each issued pixel
  typedef struct packed {
    logic ref_sample;
    logic seg_start;
    logic ref_block;
    logic blk_end;
  } vscan_flags_t;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/vscan_mod_counter.sv
module vscan_mod_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         step_i,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clear_i | step_i;
    if (clear_i)
      cnt_d = '0;
    else if (cnt_q == last_i)
      cnt_d = '0;
    else
      cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/vscan_walker.sv
module vscan_walker #(
  parameter int LINES = 16,
  parameter int COL_W = 8,
  parameter int ROW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] width_i,
  output logic             busy_o,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o,
  output logic             go_o,
  output logic             blk_end_o,
  output logic             done_o
);

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [COL_W-1:0] col_q,  col_d;
  logic [ROW_W-1:0] row_q,  row_d;
  logic [COL_W-1:0] wid_q,  wid_d;
  logic             go;
  logic             last_row;
  logic             last_col;
  logic             walk_en;

  always_comb begin
    go       = !busy_q && start_i && (width_i != '0);
    last_row = (row_q == ROW_W'(LINES - 1));
    last_col = (col_q == wid_q - COL_W'(1));
    walk_en  = go | busy_q;

    busy_d = busy_q;
    col_d  = col_q;
    row_d  = row_q;
    wid_d  = wid_q;
    done_d = 1'b0;

    if (go) begin
      busy_d = 1'b1;
      col_d  = '0;
      row_d  = '0;
      wid_d  = width_i;
    end else if (busy_q) begin
      if (last_row) begin
        row_d = '0;
        if (last_col) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          col_d = col_q + COL_W'(1);
        end
      end else begin
        row_d = row_q + ROW_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      col_q  <= '0;
      row_q  <= '0;
      wid_q  <= '0;
    end else if (walk_en) begin
      busy_q <= busy_d;
      col_q  <= col_d;
      row_q  <= row_d;
      wid_q  <= wid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      done_q <= 1'b0;
    else
      done_q <= done_d;
  end

  assign busy_o    = busy_q;
  assign col_o     = col_q;
  assign row_o     = row_q;
  assign go_o      = go;
  assign blk_end_o = busy_q && last_row;
  assign done_o    = done_q;

endmodule

// File: rtl/vscan_ri_ctl.sv
module vscan_ri_ctl #(
  parameter int RI_W       = 8,
  parameter int RI_DEFAULT = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go_i,
  input  logic            blk_end_i,
  input  logic            load_i,
  input  logic [RI_W-1:0] value_i,
  output logic            first_blk_o
);

  logic [RI_W-1:0] active_q, active_d;
  logic [RI_W-1:0] pend_q,   pend_d;
  logic            pend_v_q, pend_v_d;
  logic [RI_W-1:0] blk_idx;
  logic [RI_W-1:0] last_idx;
  logic            wrap;
  logic            boundary;
  logic            load_ok;
  logic            reg_en;

  vscan_mod_counter #(.W(RI_W)) u_blk_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (go_i),
    .step_i  (blk_end_i),
    .last_i  (last_idx),
    .cnt_o   (blk_idx)
  );

  always_comb begin
    last_idx = active_q - RI_W'(1);
    wrap     = blk_end_i && (blk_idx == last_idx);
    boundary = go_i | wrap;
    load_ok  = load_i && (value_i != '0);
    reg_en   = boundary | load_ok;

    active_d = (boundary && pend_v_q) ? pend_q : active_q;
    pend_d   = load_ok ? value_i : pend_q;
    if (load_ok)
      pend_v_d = 1'b1;
    else if (boundary)
      pend_v_d = 1'b0;
    else
      pend_v_d = pend_v_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= RI_W'(RI_DEFAULT);
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else if (reg_en) begin
      active_q <= active_d;
      pend_q   <= pend_d;
      pend_v_q <= pend_v_d;
    end
  end

  assign first_blk_o = (blk_idx == '0);

endmodule

// File: rtl/vscan_sequencer.sv
module vscan_sequencer
  import vscan_pkg::*;
#(
  parameter int LINES      = 16,
  parameter int COL_W      = 8,
  parameter int SEG_BLOCKS = 64,
  parameter int RI_W       = 8,
  parameter int RI_DEFAULT = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                start,
  input  logic [COL_W-1:0]                    width,
  input  logic                                ri_load,
  input  logic [RI_W-1:0]                     ri_value,
  output logic [COL_W+cnt_width(LINES)-1:0]   addr,
  output logic                                valid,
  output logic                                col_odd,
  output logic                                flag_ref,
  output logic                                flag_seg_start,
  output logic                                flag_ref_block,
  output logic                                flag_blk_end,
  output logic                                done
);

  localparam int ROW_W  = cnt_width(LINES);
  localparam int ADDR_W = COL_W + ROW_W;
  localparam int SEG_W  = cnt_width(SEG_BLOCKS);

  logic             busy;
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  logic             go;
  logic             blk_end;
  logic             first_blk;
  logic [SEG_W-1:0] seg_idx;
  vscan_flags_t     flg;

  vscan_walker #(
    .LINES (LINES),
    .COL_W (COL_W),
    .ROW_W (ROW_W)
  ) u_walker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .width_i   (width),
    .busy_o    (busy),
    .col_o     (col),
    .row_o     (row),
    .go_o      (go),
    .blk_end_o (blk_end),
    .done_o    (done)
  );

  vscan_ri_ctl #(
    .RI_W       (RI_W),
    .RI_DEFAULT (RI_DEFAULT)
  ) u_ri_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_i        (go),
    .blk_end_i   (blk_end),
    .load_i      (ri_load),
    .value_i     (ri_value),
    .first_blk_o (first_blk)
  );

  vscan_mod_counter #(.W(SEG_W)) u_seg_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (go),
    .step_i  (blk_end),
    .last_i  (SEG_W'(SEG_BLOCKS - 1)),
    .cnt_o   (seg_idx)
  );

  always_comb begin
    flg.blk_end    = blk_end;
    flg.ref_block  = busy && first_blk;
    flg.ref_sample = busy && first_blk && (row == '0);
    flg.seg_start  = busy && (seg_idx == '0) && (row == '0);
  end

  assign addr           = ADDR_W'(col) * ADDR_W'(LINES) + ADDR_W'(row);
  assign valid          = busy;
  assign col_odd        = busy && col[0];
  assign flag_ref       = flg.ref_sample;
  assign flag_seg_start = flg.seg_start;
  assign flag_ref_block = flg.ref_block;
  assign flag_blk_end   = flg.blk_end;

endmodule

// File: rtl/vscan_sequencer_chk.sv
module vscan_sequencer_chk #(
  parameter int LINES = 16,
  parameter int COL_W = 8
) (
  input logic                                      clk,
  input logic                                      rst_n,
  input logic [COL_W+vscan_pkg::cnt_width(LINES)-1:0] addr,
  input logic                                      valid,
  input logic                                      col_odd,
  input logic                                      flag_ref,
  input logic                                      flag_seg_start,
  input logic                                      flag_ref_block,
  input logic                                      flag_blk_end,
  input logic                                      done
);

  localparam int ROW_W = vscan_pkg::cnt_width(LINES);

  // R1: consecutive pixels take consecutive addresses
  assert_addr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(valid)) |-> (addr == $past(addr) + 1'b1));

  // R2: parity only changes across a block end
  assert_parity_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(valid) && !$past(flag_blk_end)) |-> (col_odd == $past(col_odd)));

  assert_parity_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(valid) && $past(flag_blk_end)) |-> (col_odd != $past(col_odd)));

  // R3: a row-0 pixel inside a scan follows a block end
  assert_blk_end_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(valid) && (addr[ROW_W-1:0] == '0)) |-> $past(flag_blk_end));

  // R4: reference sample lies inside the reference block
  assert_ref_in_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ref |-> (flag_ref_block && valid));

  // R5: segment start is the first pixel after a block end or of the scan
  assert_seg_on_row0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_seg_start && $past(valid)) |-> $past(flag_blk_end));

  // R7: done is a lone pulse after the last block end, with valid low
  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !valid);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(valid) && $past(flag_blk_end)));

endmodule

bind vscan_sequencer vscan_sequencer_chk #(
  .LINES (LINES),
  .COL_W (COL_W)
) u_chk (.*);

// File: tb/vscan_sequencer_tb.sv
module vscan_sequencer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LINES      = 4;
  localparam int COL_W      = 5;
  localparam int SEG_BLOCKS = 3;
  localparam int RI_W       = 4;
  localparam int RI_DEFAULT = 2;
  localparam int ADDR_W     = COL_W + 2;

  logic              clk;
  logic              rst_n;
  logic              start;
  logic [COL_W-1:0]  width;
  logic              ri_load;
  logic [RI_W-1:0]   ri_value;
  logic [ADDR_W-1:0] addr;
  logic              valid, col_odd, flag_ref, flag_seg_start;
  logic              flag_ref_block, flag_blk_end, done;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  // Bench model of the interval and segment bookkeeping (from R4..R6)
  int m_active, m_pend, m_pv, m_ri_idx, m_seg_idx;

  vscan_sequencer #(
    .LINES (LINES), .COL_W (COL_W), .SEG_BLOCKS (SEG_BLOCKS),
    .RI_W (RI_W), .RI_DEFAULT (RI_DEFAULT)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .start (start), .width (width),
    .ri_load (ri_load), .ri_value (ri_value), .addr (addr), .valid (valid),
    .col_odd (col_odd), .flag_ref (flag_ref), .flag_seg_start (flag_seg_start),
    .flag_ref_block (flag_ref_block), .flag_blk_end (flag_blk_end), .done (done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check_eq(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle_load(input int v);
    @(negedge clk);
    ri_load  = 1'b1;
    ri_value = RI_W'(v);
    @(posedge clk);
    if (v != 0) begin
      m_pend = v;
      m_pv   = 1;
    end
    @(negedge clk);
    ri_load = 1'b0;
  endtask

  // load_at: pixel index during which a load is driven (-1 for none)
  task automatic run_scan(input int w, input int load_at, input int load_val);
    int total;
    total = w * LINES;
    @(negedge clk);
    start = 1'b1;
    width = COL_W'(w);
    @(posedge clk);
    if (m_pv != 0) begin
      m_active = m_pend;
      m_pv     = 0;
    end
    m_ri_idx  = 0;
    m_seg_idx = 0;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < total; k++) begin
      int col, row;
      col = k / LINES;
      row = k % LINES;
      check_eq("R1 valid", int'(valid), 1);
      check_eq("R1 addr", int'(addr), col * LINES + row);
      check_eq("R2 col_odd", int'(col_odd), col % 2);
      check_eq("R3 blk_end", int'(flag_blk_end), (row == LINES - 1) ? 1 : 0);
      check_eq("R4 ref_block", int'(flag_ref_block), (m_ri_idx == 0) ? 1 : 0);
      check_eq("R4 ref", int'(flag_ref), (m_ri_idx == 0 && row == 0) ? 1 : 0);
      check_eq("R5 seg_start", int'(flag_seg_start), (m_seg_idx == 0 && row == 0) ? 1 : 0);
      if (k == load_at) begin
        ri_load  = 1'b1;
        ri_value = RI_W'(load_val);
      end
      if (k == 5) start = 1'b1;  // R8: start while busy
      @(posedge clk);
      if (row == LINES - 1) begin
        m_seg_idx = (m_seg_idx == SEG_BLOCKS - 1) ? 0 : m_seg_idx + 1;
        if (m_ri_idx == m_active - 1) begin
          m_ri_idx = 0;
          if (m_pv != 0) begin
            m_active = m_pend;
            m_pv     = 0;
          end
        end else begin
          m_ri_idx++;
        end
      end
      if (k == load_at && load_val != 0) begin
        m_pend = load_val;
        m_pv   = 1;
      end
      @(negedge clk);
      ri_load = 1'b0;
      start   = 1'b0;
    end
    check_eq("R7 done after last", int'(done), 1);
    check_eq("R7 valid low with done", int'(valid), 0);
    @(negedge clk);
    check_eq("R7 done single", int'(done), 0);
    check_eq("R8 no restart", int'(valid), 0);
  endtask

  initial begin
    rst_n    = 1'b0;
    start    = 1'b0;
    width    = '0;
    ri_load  = 1'b0;
    ri_value = '0;
    m_active = RI_DEFAULT;
    m_pend   = 0;
    m_pv     = 0;
    m_ri_idx = 0;
    m_seg_idx = 0;
    repeat (3) @(negedge clk);
    check_eq("R9 valid", int'(valid), 0);
    check_eq("R9 done", int'(done), 0);
    check_eq("R9 addr", int'(addr), 0);
    check_eq("R9 flags", int'({flag_ref, flag_seg_start, flag_ref_block, flag_blk_end, col_odd}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R9 idle after release", int'(valid), 0);

    run_scan(1, -1, 0);        // single column
    run_scan(7, -1, 0);        // default interval, segment wraps
    idle_load(3);              // R6: pending applied at start
    run_scan(9, -1, 0);
    run_scan(10, 2, 1);        // R6: mid-interval load waits for boundary
    idle_load(0);              // R6: zero load ignored, interval stays 1
    run_scan(6, -1, 0);

    // R8: width zero start is ignored
    @(negedge clk);
    start = 1'b1;
    width = '0;
    @(negedge clk);
    start = 1'b0;
    check_eq("R8 zero width valid", int'(valid), 0);
    @(negedge clk);
    check_eq("R8 zero width valid later", int'(valid), 0);
    check_eq("R8 zero width done", int'(done), 0);

    idle_load(5);
    run_scan(31, 40, 2);       // widest strip with a reload

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule